// File: doc/BRIEF.md
# IO Pad Deep Power-Down Sequencer

This block sits on a simple word-addressed register bus and decides when groups of IO pad rails enter or leave deep power-down. Software writes a request word into one of two bank registers. The top two bits of the word carry a command code, and the low bits pick one or more rails of that bank. The block waits a programmable number of bus clock cycles and then updates the per-rail power-down state. Software reads that state back from a status register in the same bank and polls until the rails it selected show the value it wants.

A sample-enable register gates the whole mechanism. While it is clear, request words are stored but have no effect. The settle-cycle register is meant to hold the number of bus clocks that covers at least 200 ns, rounded up. Its reset value of 25 suits a 125 MHz bus clock. The per-rail state also drives a flat output vector toward the pad ring.

Top module: `pad_dpd_top`

## Requirements
- R1: After reset, every rail state bit is 0 (rail powered), sample enable reads 0, and the settle register reads 25.
- R2: Word address 0 holds sample enable in bit 0, and address 1 holds the settle count in bits 15:0. Addresses 2 and 4 are the request words of bank 0 and bank 1 and read back the last word written. Addresses 3 and 5 return that bank's 30 rail state bits in bits 29:0, with bits 31:30 reading 0.
- R3: Command code 2 in bits 31:30 drives each selected rail state to 1 (in power-down). Code 1 drives each selected rail state to 0 (released).
- R4: Command codes 0 and 3 change no rail state and start no settle count.
- R5: Bits 29:0 of a request word select rails. Bank 0 bit k is rail k (railDpd[k]), and bank 1 bit k is railDpd[30+k].
- R6: With settle value S at the time a request is accepted, the rail state changes on the (S+1)th rising clock edge after the edge that accepts the write. S = 0 gives a change on the next edge. At no other time does the state change.
- R7: Rails that no pending request selected keep their state when a request completes.
- R8: A request written while sample enable is 0 has no effect on rail state, now or later.
- R9: Clearing sample enable while a request is waiting abandons it. Its rails never change, even after sample enable is set again.
- R10: An accepted request that arrives while another is waiting merges its selection into the pending set, overrides the target of any rail it selects again, and restarts the settle count from the current settle value.
- R11: The railDpd output always equals the rail state reported in the status registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for one cycle |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| railDpd | output | 60 | Per-rail power-down state, 1 = in deep power-down |

## Verification
A corrupted pending mask or target appears on railDpd on the very edge the settle count finishes. A bad count shows up as a change one or more cycles early or late. The bench compares railDpd with its own model on every cycle, so any of these faults is reported within one clock of the wrong edge. A pending set that survives a cleared sample enable stays hidden until the next accepted request completes. The abandon test therefore re-enables sampling and watches long enough for a stale request to surface.

// File: rtl/pad_dpd_pkg.sv
package pad_dpd_pkg;

  localparam int unsigned BANK_COUNT = 2;
  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_SAMPLE = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_SETTLE = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_REQ0   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT0  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_REQ1   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT1  = 3'd5;

  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_RELEASE = 2'd1,
    CMD_ENTER   = 2'd2,
    CMD_RSVD    = 2'd3
  } dpdCmd_e;

  typedef struct packed {
    logic sampleWr;
    logic settleWr;
    logic reqWr;
    logic bankSel;
    logic load;
    logic enter;
    logic apply;
    logic drop;
  } dpdStrobe_t;

endpackage

// File: rtl/pad_dpd_ctrl.sv
module pad_dpd_ctrl
  import pad_dpd_pkg::*;
#(
  parameter int unsigned TIMER_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [1:0]            cmdCode,
  input  logic                  sampleEn,
  input  logic [TIMER_W-1:0]    settleCycles,
  output dpdStrobe_t            strb
);

  dpdCmd_e             cmd;
  logic                reqHit;
  logic                cmdValid;
  logic                accept;
  logic                busyQ;
  logic [TIMER_W-1:0]  cntQ;

  assign cmd      = dpdCmd_e'(cmdCode);
  assign reqHit   = busWe && (busAddr == ADDR_REQ0 || busAddr == ADDR_REQ1);
  assign cmdValid = (cmd == CMD_RELEASE) || (cmd == CMD_ENTER);
  assign accept   = reqHit && cmdValid && sampleEn;

  always_comb begin
    strb          = '0;
    strb.sampleWr = busWe && (busAddr == ADDR_SAMPLE);
    strb.settleWr = busWe && (busAddr == ADDR_SETTLE);
    strb.reqWr    = reqHit;
    strb.bankSel  = (busAddr == ADDR_REQ1);
    strb.load     = accept;
    strb.enter    = (cmd == CMD_ENTER);
    strb.apply    = busyQ && (cntQ == '0) && sampleEn && !accept;
    strb.drop     = !sampleEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      cntQ  <= settleCycles;
    end else if (!sampleEn) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - TIMER_W'(1);
    end
  end

  // R6
  restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busyQ && cntQ == $past(settleCycles)));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ != '0 && sampleEn && !accept) |=> (busyQ && cntQ == $past(cntQ) - TIMER_W'(1)));

  // R9
  abandon_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !sampleEn) |=> !busyQ);

endmodule

// File: rtl/pad_dpd_datapath.sv
module pad_dpd_datapath
  import pad_dpd_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned TIMER_W        = 16,
  parameter int unsigned RAILS_PER_BANK = 30,
  parameter int unsigned SETTLE_RESET   = 25
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dpdStrobe_t                           strb,
  input  logic [REG_ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                    busWdata,
  output logic                                 sampleEn,
  output logic [TIMER_W-1:0]                   settleCycles,
  output logic [DATA_W-1:0]                    busRdata,
  output logic [BANK_COUNT*RAILS_PER_BANK-1:0] railDpd
);

  localparam int unsigned TOTAL = BANK_COUNT * RAILS_PER_BANK;

  logic                      sampleQ;
  logic [TIMER_W-1:0]        settleQ;
  logic [DATA_W-1:0]         reqWordQ [BANK_COUNT];
  logic [TOTAL-1:0]          statusQ;
  logic [TOTAL-1:0]          pendMaskQ;
  logic [TOTAL-1:0]          pendTgtQ;
  logic [TOTAL-1:0]          maskNext;
  logic [TOTAL-1:0]          tgtNext;
  logic [RAILS_PER_BANK-1:0] selBits;

  assign selBits = busWdata[RAILS_PER_BANK-1:0];

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    localparam int unsigned LO = b * RAILS_PER_BANK;
    logic loadHere;
    assign loadHere = strb.load && (strb.bankSel == 1'(b));
    assign maskNext[LO +: RAILS_PER_BANK] = loadHere
      ? (pendMaskQ[LO +: RAILS_PER_BANK] | selBits)
      : pendMaskQ[LO +: RAILS_PER_BANK];
    assign tgtNext[LO +: RAILS_PER_BANK] = loadHere
      ? ((pendTgtQ[LO +: RAILS_PER_BANK] & ~selBits) | (strb.enter ? selBits : '0))
      : pendTgtQ[LO +: RAILS_PER_BANK];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleQ   <= 1'b0;
      settleQ   <= TIMER_W'(SETTLE_RESET);
      statusQ   <= '0;
      pendMaskQ <= '0;
      pendTgtQ  <= '0;
      for (int i = 0; i < BANK_COUNT; i++) reqWordQ[i] <= '0;
    end else begin
      if (strb.sampleWr) sampleQ <= busWdata[0];
      if (strb.settleWr) settleQ <= busWdata[TIMER_W-1:0];
      for (int i = 0; i < BANK_COUNT; i++) begin
        if (strb.reqWr && strb.bankSel == 1'(i)) reqWordQ[i] <= busWdata;
      end
      pendTgtQ <= tgtNext;
      if (strb.drop) begin
        pendMaskQ <= '0;
      end else if (strb.apply) begin
        statusQ   <= (statusQ & ~pendMaskQ) | (pendTgtQ & pendMaskQ);
        pendMaskQ <= '0;
      end else begin
        pendMaskQ <= maskNext;
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_SAMPLE: busRdata = DATA_W'(sampleQ);
      ADDR_SETTLE: busRdata = DATA_W'(settleQ);
      ADDR_REQ0:   busRdata = reqWordQ[0];
      ADDR_STAT0:  busRdata = DATA_W'(statusQ[0 +: RAILS_PER_BANK]);
      ADDR_REQ1:   busRdata = reqWordQ[1];
      ADDR_STAT1:  busRdata = DATA_W'(statusQ[RAILS_PER_BANK +: RAILS_PER_BANK]);
      default:     busRdata = '0;
    endcase
  end

  assign sampleEn     = sampleQ;
  assign settleCycles = settleQ;
  assign railDpd      = statusQ;

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.apply |=> $stable(statusQ));

  // R7
  unselected_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> (((statusQ ^ $past(statusQ)) & ~$past(pendMaskQ)) == '0));

  // R3
  apply_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> (((statusQ ^ $past(pendTgtQ)) & $past(pendMaskQ)) == '0));

  // R9
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.drop |=> (pendMaskQ == '0));

endmodule

// File: rtl/pad_dpd_top.sv
module pad_dpd_top
  import pad_dpd_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned TIMER_W        = 16,
  parameter int unsigned RAILS_PER_BANK = 30,
  parameter int unsigned SETTLE_RESET   = 25
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 busWe,
  input  logic [REG_ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                    busWdata,
  output logic [DATA_W-1:0]                    busRdata,
  output logic [BANK_COUNT*RAILS_PER_BANK-1:0] railDpd
);

  dpdStrobe_t          strb;
  logic                sampleEn;
  logic [TIMER_W-1:0]  settleCycles;

  pad_dpd_ctrl #(
    .TIMER_W (TIMER_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .busWe        (busWe),
    .busAddr      (busAddr),
    .cmdCode      (busWdata[DATA_W-1:DATA_W-2]),
    .sampleEn     (sampleEn),
    .settleCycles (settleCycles),
    .strb         (strb)
  );

  pad_dpd_datapath #(
    .DATA_W         (DATA_W),
    .TIMER_W        (TIMER_W),
    .RAILS_PER_BANK (RAILS_PER_BANK),
    .SETTLE_RESET   (SETTLE_RESET)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .sampleEn     (sampleEn),
    .settleCycles (settleCycles),
    .busRdata     (busRdata),
    .railDpd      (railDpd)
  );

endmodule

// File: tb/pad_dpd_top_tb_top.sv
module pad_dpd_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWe;
  logic [2:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [59:0] railDpd;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pad_dpd_top dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .railDpd  (railDpd)
  );

  // Behavioural reference model
  logic [59:0] mStat, mPend, mTgt;
  bit          mEn, mBusy;
  int          mCnt, mSet;

  always @(posedge clk) begin : model
    logic [1:0] c;
    bit         isReq, accepted;
    int         base;
    if (!rstN) begin
      mStat = '0; mPend = '0; mTgt = '0;
      mEn = 0; mBusy = 0; mCnt = 0; mSet = 25;
    end else begin
      c        = busWdata[31:30];
      isReq    = busWe && (busAddr == 3'd2 || busAddr == 3'd4);
      base     = (busAddr == 3'd4) ? 30 : 0;
      accepted = isReq && (c == 2'd1 || c == 2'd2) && mEn;
      if (accepted) begin
        for (int k = 0; k < 30; k++) begin
          if (busWdata[k]) begin
            mPend[base+k] = 1'b1;
            mTgt[base+k]  = (c == 2'd2);
          end
        end
        mCnt  = mSet;
        mBusy = 1;
      end else if (!mEn) begin
        mBusy = 0;
        mPend = '0;
      end else if (mBusy) begin
        if (mCnt == 0) begin
          for (int k = 0; k < 60; k++) if (mPend[k]) mStat[k] = mTgt[k];
          mPend = '0;
          mBusy = 0;
        end else begin
          mCnt = mCnt - 1;
        end
      end
      if (busWe && busAddr == 3'd0) mEn = busWdata[0];
      if (busWe && busAddr == 3'd1) mSet = int'(busWdata[15:0]);
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R11: output mirrors model state on every cycle
  always @(negedge clk) begin
    if (rstN === 1'b1 && !finished) check("R11 railDpd vs model", 64'(railDpd), 64'(mStat));
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  initial begin : stim
    logic [31:0] d;
    rstN = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, d); check("R1 bank0 status", 64'(d), 64'h0);
    rd(3'd5, d); check("R1 bank1 status", 64'(d), 64'h0);
    rd(3'd1, d); check("R1 settle reset", 64'(d), 64'd25);
    rd(3'd0, d); check("R1 sample enable", 64'(d), 64'h0);
    check("R1 railDpd", 64'(railDpd), 64'h0);

    // R8 request ignored while sampling disabled
    wr(3'd2, 32'h8000_0005);
    idle(30);
    check("R8 no change when disabled", 64'(railDpd), 64'h0);
    rd(3'd2, d); check("R2 request readback", 64'(d), 64'h8000_0005);

    wr(3'd0, 32'h1);
    wr(3'd1, 32'd5);
    rd(3'd0, d); check("R2 sample readback", 64'(d), 64'h1);
    rd(3'd1, d); check("R2 settle readback", 64'(d), 64'd5);

    // R3 enter, R6 exact timing with S=5
    wr(3'd2, 32'h8000_0003);
    idle(5);
    check("R6 not yet at edge S", 64'(railDpd[29:0]), 64'h0);
    @(negedge clk);
    check("R6 changed at edge S+1", 64'(railDpd[29:0]), 64'h3);
    rd(3'd3, d); check("R3 enter sets bits", 64'(d), 64'h3);

    // R5 bank 1 mapping
    wr(3'd4, 32'hA000_0001);
    idle(8);
    check("R5 bank1 rails", 64'(railDpd[59:30]), 64'h2000_0001);
    rd(3'd5, d); check("R5 bank1 status", 64'(d), 64'h2000_0001);
    check("R7 bank0 kept", 64'(railDpd[29:0]), 64'h3);

    // R3 release, R7 neighbours kept
    wr(3'd2, 32'h4000_0001);
    idle(8);
    rd(3'd3, d); check("R3 release clears bit", 64'(d), 64'h2);
    check("R7 bank1 kept", 64'(railDpd[59:30]), 64'h2000_0001);

    // R4 idle and reserved codes
    wr(3'd2, 32'h3FFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    idle(10);
    rd(3'd3, d); check("R4 idle/reserved no effect", 64'(d), 64'h2);

    // R10 restart and merge
    wr(3'd1, 32'd6);
    wr(3'd2, 32'h8000_0050);
    idle(2);
    wr(3'd2, 32'h4000_0042);
    idle(6);
    check("R10 restart delays update", 64'(railDpd[29:0]), 64'h2);
    @(negedge clk);
    check("R10 merged result", 64'(railDpd[29:0]), 64'h10);

    // R9 abandon on sample disable
    wr(3'd1, 32'd10);
    wr(3'd4, 32'h8000_0020);
    idle(2);
    wr(3'd0, 32'h0);
    idle(20);
    check("R9 abandoned while disabled", 64'(railDpd[59:30]), 64'h2000_0001);
    wr(3'd0, 32'h1);
    idle(15);
    check("R9 not resurrected", 64'(railDpd[59:30]), 64'h2000_0001);

    // R6 zero settle
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h8000_0200);
    check("R6 S=0 before edge", 64'(railDpd[29:0]), 64'h10);
    @(negedge clk);
    check("R6 S=0 next edge", 64'(railDpd[29:0]), 64'h210);
    rd(3'd3, d); check("R2 status top bits zero", 64'(d), 64'h210);

    idle(3);
    finish_run();
  end

endmodule